// File: doc/BRIEF.md
# Fuse-Backed Firmware Version Floor Guard

This block keeps a boot controller from starting a firmware image older than the oldest version still allowed. The allowed floor lives in a bank of one-time-programmable bits, modelled here as sticky register bits that can be set but never cleared. The floor is held as a thermometer code: the number of set bits counted upward from bit 0 is the lowest acceptable image version. An image version, taken from a header that has already been verified elsewhere, is presented on a valid/ready check channel. One cycle later the block returns a verdict: accept or reject.

The floor never moves when a check is made. It moves only when the boot controller sends a commit strobe after the new firmware has confirmed itself. The commit carries the new version on the same version bus. The bank then sets every bit below that version. A commit beyond the bank's size fills the bank and raises the exhausted flag. A corrupt bank, meaning a set bit above the first clear bit, raises a fault flag. While the fault flag is high, every image is rejected and no bits are burned.

Back-pressure rules for the check channel: a check is taken on a rising clock edge where `chk_valid_i` and `chk_ready_o` are both high. `chk_ready_o` is low in any cycle where `commit_i` is high, so a commit always wins that cycle. The requester must hold `chk_valid_i` and `ver_i` steady until the check is taken. Its verdict is then judged against the floor that the commit has just raised. The verdict side is a plain pulse with no back-pressure.

Top module: `fuse_floor_guard`

## Requirements
- R1: A check whose version is below the current floor yields `vrd_accept_o` = 0.
- R2: A check whose version is equal to or above the floor, with no fault present, yields `vrd_accept_o` = 1.
- R3: `vrd_valid_o` is high for exactly the one cycle after each check handshake and low otherwise. `vrd_accept_o` holds its value until the next verdict.
- R4: The floor is the count of contiguous set bits from bit 0 of the bank. After reset the bank holds the parameter `INIT_FUSES`.
- R5: If any set bit lies above the lowest clear bit, `fault_o` is 1, every check is rejected and every commit leaves the bank unchanged.
- R6: A commit with version V above the floor sets bank bits 0..V-1. A check taken on any later edge is judged against the new floor V. Bank bits are never cleared.
- R7: A commit with version equal to or below the floor leaves the bank and the floor unchanged.
- R8: A commit with version at or above `FUSE_W` sets every bank bit. `exhausted_o` is 1 exactly when all bank bits are set.
- R9: A check, accepted or not, never changes the floor.
- R10: `chk_ready_o` is 0 in a cycle with `commit_i` = 1. A check held through that cycle is taken afterwards and judged against the updated floor.
- R11: While `rst_n` is low, `vrd_valid_o` and `vrd_accept_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; loads the sensed bank pattern |
| ver_i | input | VER_W | Image version for a check, or new version for a commit |
| chk_valid_i | input | 1 | Check request valid |
| chk_ready_o | output | 1 | Check request can be taken this cycle |
| commit_i | input | 1 | Confirmed-firmware commit strobe |
| vrd_valid_o | output | 1 | Verdict valid pulse |
| vrd_accept_o | output | 1 | Verdict: 1 accept, 0 reject |
| fault_o | output | 1 | Bank pattern is not a thermometer code |
| exhausted_o | output | 1 | All bank bits are set |

## Verification
The main instance is built with `FUSE_W` = 32, the smallest allowed bank, and `VER_W` = 8. This lets random versions go well past the bank size, so saturation and the exhausted flag are reached inside a short run. Its `INIT_FUSES` starts the floor at 3, which puts reject cases below the floor within reach from the first check. A second instance is built with a broken pattern (bits 0, 2 and 8 set). It starts in the fault state, which lets the bench drive forced rejects and ignored commits.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

  typedef enum logic {
    VERDICT_REJECT = 1'b0,
    VERDICT_ACCEPT = 1'b1
  } verdict_e;

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ffg_decode.sv
module ffg_decode #(
  parameter int FUSE_W = 32,
  parameter int CNT_W  = $clog2(FUSE_W + 1)
) (
  input  logic [FUSE_W-1:0] fuse_i,
  output logic [CNT_W-1:0]  floor_o,
  output logic              fault_o
);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] pop_cnt;
  logic             run;

  // Count the unbroken run of set bits from bit 0, and the total number of set bits.
  always_comb begin
    run     = 1'b1;
    run_cnt = '0;
    pop_cnt = '0;
    for (int i = 0; i < FUSE_W; i++) begin
      run     = run & fuse_i[i];
      run_cnt = run_cnt + CNT_W'(run);
      pop_cnt = pop_cnt + CNT_W'(fuse_i[i]);
    end
  end

  assign floor_o = run_cnt;
  // Any set bit outside the unbroken run means the pattern is not a thermometer code.
  assign fault_o = (pop_cnt != run_cnt);

endmodule

// File: rtl/ffg_bank.sv
module ffg_bank #(
  parameter int                FUSE_W     = 32,
  parameter int                VER_W      = 8,
  parameter int                CNT_W      = $clog2(FUSE_W + 1),
  parameter logic [FUSE_W-1:0] INIT_FUSES = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic [CNT_W-1:0]  floor_i,
  input  logic              fault_i,
  output logic [FUSE_W-1:0] fuse_o,
  output logic              exhausted_o
);
  import ffg_pkg::*;

  localparam int CMP_W = wider(VER_W, CNT_W);

  logic [FUSE_W-1:0] fuse_q;
  logic [FUSE_W-1:0] thermo;
  logic              raise;

  // Thermometer image of the commit version; it saturates at all ones by construction.
  always_comb begin
    for (int i = 0; i < FUSE_W; i++) begin
      thermo[i] = (int'(ver_i) > i);
    end
  end

  assign raise = commit_i && !fault_i && (CMP_W'(ver_i) > CMP_W'(floor_i));

  // Bits are only ever ORed in; reset models the power-up sense of the programmed pattern.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fuse_q <= INIT_FUSES;
    end else if (raise) begin
      fuse_q <= fuse_q | thermo;
    end
  end

  assign fuse_o      = fuse_q;
  assign exhausted_o = &fuse_q;

  // R6
  fuse_only_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));

  // R7
  low_commit_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && (CMP_W'(ver_i) <= CMP_W'(floor_i))) |=> $stable(fuse_q));

  // R5
  fault_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> $stable(fuse_q));

  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !fault_i && (int'(ver_i) >= FUSE_W)) |=> exhausted_o);

  // R9
  idle_no_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(fuse_q));

endmodule

// File: rtl/ffg_judge.sv
module ffg_judge #(
  parameter int VER_W = 8,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [VER_W-1:0] ver_i,
  input  logic [CNT_W-1:0] floor_i,
  input  logic             fault_i,
  output logic             vrd_valid_o,
  output logic             vrd_accept_o
);
  import ffg_pkg::*;

  localparam int CMP_W = wider(VER_W, CNT_W);

  verdict_e verdict_d;
  verdict_e verdict_q;
  logic     valid_q;

  always_comb begin
    if (fault_i || (CMP_W'(ver_i) < CMP_W'(floor_i))) begin
      verdict_d = VERDICT_REJECT;
    end else begin
      verdict_d = VERDICT_ACCEPT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= VERDICT_REJECT;
    end else begin
      valid_q <= fire_i;
      if (fire_i) begin
        verdict_q <= verdict_d;
      end
    end
  end

  assign vrd_valid_o  = valid_q;
  assign vrd_accept_o = (verdict_q == VERDICT_ACCEPT);

  // R1
  below_floor_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && (CMP_W'(ver_i) < CMP_W'(floor_i))) |=> !vrd_accept_o);

  // R5
  fault_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && fault_i) |=> !vrd_accept_o);

  // R3
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(vrd_accept_o));

endmodule

// File: rtl/fuse_floor_guard.sv
module fuse_floor_guard #(
  parameter int                FUSE_W     = 32,
  parameter int                VER_W      = 8,
  parameter logic [FUSE_W-1:0] INIT_FUSES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VER_W-1:0] ver_i,
  input  logic             chk_valid_i,
  output logic             chk_ready_o,
  input  logic             commit_i,
  output logic             vrd_valid_o,
  output logic             vrd_accept_o,
  output logic             fault_o,
  output logic             exhausted_o
);

  localparam int CNT_W = $clog2(FUSE_W + 1);

  logic [FUSE_W-1:0] fuse_w;
  logic [CNT_W-1:0]  floor_w;
  logic              fault_w;
  logic              fire;

  // A commit takes the cycle; a pending check waits.
  assign chk_ready_o = !commit_i;
  assign fire        = chk_valid_i && chk_ready_o;

  ffg_decode #(.FUSE_W(FUSE_W), .CNT_W(CNT_W)) u_decode (
    .fuse_i  (fuse_w),
    .floor_o (floor_w),
    .fault_o (fault_w)
  );

  ffg_bank #(.FUSE_W(FUSE_W), .VER_W(VER_W), .CNT_W(CNT_W), .INIT_FUSES(INIT_FUSES)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit_i),
    .ver_i       (ver_i),
    .floor_i     (floor_w),
    .fault_i     (fault_w),
    .fuse_o      (fuse_w),
    .exhausted_o (exhausted_o)
  );

  ffg_judge #(.VER_W(VER_W), .CNT_W(CNT_W)) u_judge (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire),
    .ver_i        (ver_i),
    .floor_i      (floor_w),
    .fault_i      (fault_w),
    .vrd_valid_o  (vrd_valid_o),
    .vrd_accept_o (vrd_accept_o)
  );

  assign fault_o = fault_w;

  // R3
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && chk_ready_o) |=> vrd_valid_o);

  // R3
  no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_valid_i && chk_ready_o) |=> !vrd_valid_o);

  // R10
  held_check_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && commit_i) |=> !vrd_valid_o);

endmodule

// File: tb/sim_fuse_floor_guard.sv
module sim_fuse_floor_guard;

  localparam int  FW  = 32;
  localparam int  VW  = 8;
  localparam time CLK = 20ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] ver = '0;
  logic          chk_valid = 1'b0;
  logic          commit = 1'b0;
  logic          chk_ready, vrd_valid, vrd_accept, fault, exhausted;

  logic [VW-1:0] ver1 = '0;
  logic          chk1 = 1'b0;
  logic          cm1 = 1'b0;
  logic          rdy1, vv1, va1, flt1, ex1;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_min  = 3;

  always #(CLK/2) clk = ~clk;

  fuse_floor_guard #(.FUSE_W(FW), .VER_W(VW), .INIT_FUSES(32'h0000_0007)) u0 (
    .clk(clk), .rst_n(rst_n), .ver_i(ver), .chk_valid_i(chk_valid), .chk_ready_o(chk_ready),
    .commit_i(commit), .vrd_valid_o(vrd_valid), .vrd_accept_o(vrd_accept),
    .fault_o(fault), .exhausted_o(exhausted));

  fuse_floor_guard #(.FUSE_W(FW), .VER_W(VW), .INIT_FUSES(32'h0000_0105)) u1 (
    .clk(clk), .rst_n(rst_n), .ver_i(ver1), .chk_valid_i(chk1), .chk_ready_o(rdy1),
    .commit_i(cm1), .vrd_valid_o(vv1), .vrd_accept_o(va1),
    .fault_o(flt1), .exhausted_o(ex1));

  function automatic int want_accept(input int v, input int floor_v);
    return (v >= floor_v) ? 1 : 0;
  endfunction

  function automatic int after_commit(input int v, input int floor_v);
    if (v <= floor_v) return floor_v;
    return (v > FW) ? FW : v;
  endfunction

  task automatic expect_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_check(input int v, input string req);
    @(negedge clk);
    ver = VW'(v);
    chk_valid = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq({req, " verdict valid"}, int'(vrd_valid), 1);
    expect_eq({req, " verdict"}, int'(vrd_accept), want_accept(v, exp_min));
  endtask

  task automatic do_commit(input int v);
    @(negedge clk);
    ver = VW'(v);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    exp_min = after_commit(v, exp_min);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    expect_eq("R11 valid in reset", int'(vrd_valid), 0);
    expect_eq("R11 accept in reset", int'(vrd_accept), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 initial floor 3 from INIT pattern, no fault, not exhausted
    expect_eq("R4 fault clear", int'(fault), 0);
    expect_eq("R8 not exhausted", int'(exhausted), 0);
    expect_eq("R10 ready idle", int'(chk_ready), 1);
    do_check(2, "R1 below init floor");
    do_check(3, "R2 at init floor");
    do_check(4, "R4 above floor");

    // R3 pulse width and hold of accept
    @(negedge clk);
    expect_eq("R3 valid drops", int'(vrd_valid), 0);
    expect_eq("R3 accept held", int'(vrd_accept), 1);

    // R9 accepted high check does not move floor
    do_check(20, "R9 high accept");
    do_check(4, "R9 floor unchanged");

    // R6 commit raises floor
    do_commit(10);
    do_check(9, "R6 below new floor");
    do_check(10, "R6 at new floor");
    // R7 lower commit ignored
    do_commit(5);
    do_check(9, "R7 floor kept after low commit");
    do_commit(10);
    do_check(9, "R7 floor kept after equal commit");

    // R10 commit and check in same cycle
    @(negedge clk);
    ver = VW'(14);
    commit = 1'b1;
    chk_valid = 1'b1;
    #1;
    expect_eq("R10 ready low on commit", int'(chk_ready), 0);
    @(negedge clk);
    commit = 1'b0;
    exp_min = after_commit(14, exp_min);
    expect_eq("R10 no verdict while held", int'(vrd_valid), 0);
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq("R10 held check taken", int'(vrd_valid), 1);
    expect_eq("R10 judged on new floor", int'(vrd_accept), 1);
    do_check(13, "R10 floor is 14");

    // Random mix
    for (int k = 0; k < 80; k++) begin
      int op;
      int v;
      op = int'($urandom_range(0, 3));
      v  = exp_min - 3 + int'($urandom_range(0, 8));
      if (v < 0) v = 0;
      if (op == 0 && exp_min < FW - 2) begin
        do_commit(v);
      end else begin
        do_check(v, (v < exp_min) ? "R1 random" : "R2 random");
      end
    end

    // R8 saturation
    do_commit(45);
    @(negedge clk);
    expect_eq("R8 exhausted", int'(exhausted), 1);
    do_check(31, "R8 below full floor");
    do_check(32, "R8 at full floor");
    do_check(200, "R8 far above");

    // R5 faulted instance
    expect_eq("R5 fault flag", int'(flt1), 1);
    @(negedge clk);
    ver1 = VW'(250);
    chk1 = 1'b1;
    @(negedge clk);
    chk1 = 1'b0;
    expect_eq("R5 verdict valid", int'(vv1), 1);
    expect_eq("R5 forced reject", int'(va1), 0);
    @(negedge clk);
    ver1 = VW'(40);
    cm1 = 1'b1;
    @(negedge clk);
    cm1 = 1'b0;
    @(negedge clk);
    expect_eq("R5 commit ignored fault stays", int'(flt1), 1);
    expect_eq("R5 commit ignored not exhausted", int'(ex1), 0);

    finish_run();
  end

endmodule